// File: doc/BRIEF.md
# Passive I2C Transaction Decoder

This block listens to the two wires of an I2C bus without ever driving them. Both lines are brought into the fast system clock domain through a synchroniser. The block then compares each sample with the one before it to find start, repeated-start and stop conditions and the rising clock edges that carry data bits.

Each completed item produces a single-cycle event on the output. The event carries a 3-bit code, a byte-wide value and a flag that is set when the acknowledge bit was a NACK. An address byte also records the transfer direction, and that direction is attached to every data byte that follows it until the next start or stop. A logging or protocol-checking engine downstream can therefore rebuild a full transaction from the event stream alone.

Top module: `i2c_snoop`

## Requirements
- R1: When the decoder is idle, a fall of SDA while SCL is high emits a START event (code 0), and the decoder begins collecting an address byte.
- R2: A START found while collecting data bytes, with no STOP since the previous START, emits a repeated-START event (code 1). A STOP clears this history, so the next START after a STOP is again code 0.
- R3: While collecting data bytes, a rise of SDA while SCL is high emits a STOP event (code 6) and returns the decoder to idle.
- R4: A bit is taken on each rising edge of SCL, most significant bit first. The first eight edges of an item carry the payload and the ninth carries the acknowledge bit. The NACK flag of the event is 1 when that acknowledge bit was 1.
- R5: An address byte emits code 2 when its lowest bit is 1 (read) and code 3 when that bit is 0 (write). With the default RAW_ADDR=0 the value reported is the upper seven bits shifted down by one. With RAW_ADDR=1 it is the whole byte.
- R6: Data bytes after an address emit code 4 if that address was a read and code 5 if it was a write. The direction stays fixed for every data byte until the next START or STOP.
- R7: While the address byte is being collected, SDA changes with SCL high are not treated as START or STOP. No event appears, and the address byte that follows decodes normally.
- R8: While collecting data, a sample in which SCL rises counts as a data bit even if SDA falls in the same sample. It is never reported as a repeated START.
- R9: START, repeated-START and STOP events carry a value of 0 and a NACK flag of 0.
- R10: No event is emitted during reset or while the bus is idle. The first sample after reset only loads the stored previous line levels.
- R11: Both lines pass through SYNC_STAGES flip-flops (at least 2) before any edge detection. Each bus item produces exactly one event, lasting one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous to clk |
| sda_i | input | 1 | Bus data line, asynchronous to clk |
| evt_valid_o | output | 1 | One-cycle strobe marking a decoded event |
| evt_cmd_o | output | 3 | Event code: 0 start, 1 repeated start, 2 address read, 3 address write, 4 data read, 5 data write, 6 stop |
| evt_data_o | output | BYTE_W | Address or data value; 0 for start, repeated start and stop |
| evt_nack_o | output | 1 | 1 when the acknowledge bit of the item was high |

## Verification
The bench targets the cases where the decoder state matters. It toggles SDA while SCL is high in the middle of the address phase; a decoder that checks conditions there would emit a spurious STOP and START and lose the address. It issues a repeated START before a read, then a fresh START after a STOP; a decoder that mishandles the history flag mislabels one of the two. It also sends a data bit in which SCL rises in the same sample as SDA falls; if a START were given priority over the bit, the byte would be cut short and a false repeated START would appear.

// File: rtl/i2c_snoop_pkg.sv
package i2c_snoop_pkg;

   typedef enum logic [2:0] {
      EV_START    = 3'd0,
      EV_RESTART  = 3'd1,
      EV_ADDR_RD  = 3'd2,
      EV_ADDR_WR  = 3'd3,
      EV_DATA_RD  = 3'd4,
      EV_DATA_WR  = 3'd5,
      EV_STOP     = 3'd6
   } evt_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } snoop_state_e;

endpackage

// File: rtl/i2c_snoop_sync.sv
module i2c_snoop_sync #(
   parameter int                STAGES  = 2,
   parameter int                LINES   = 2,
   parameter logic [LINES-1:0]  RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d_i,
   output logic [LINES-1:0] q_o
);

   logic [LINES-1:0] pipe [STAGES];

   initial begin
      assert (STAGES >= 2) else $fatal(1, "i2c_snoop_sync: STAGES must be at least 2");
      assert (LINES >= 1)  else $fatal(1, "i2c_snoop_sync: LINES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d_i;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/i2c_snoop_edge.sv
module i2c_snoop_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_q;
   logic sda_q;
   logic primed_q;

   // The first sample after reset only fills scl_q / sda_q.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         primed_q <= 1'b0;
      end else begin
         scl_q    <= scl_i;
         sda_q    <= sda_i;
         primed_q <= 1'b1;
      end
   end

   assign scl_rise_o = primed_q & ~scl_q & scl_i;
   assign start_o    = primed_q & sda_q & ~sda_i & scl_i;
   assign stop_o     = primed_q & ~sda_q & sda_i & scl_i;

endmodule

// File: rtl/i2c_snoop_fsm.sv
module i2c_snoop_fsm
   import i2c_snoop_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter bit RAW_ADDR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              sda_i,
   output logic              evt_valid_o,
   output evt_cmd_e          evt_cmd_o,
   output logic [BYTE_W-1:0] evt_data_o,
   output logic              evt_nack_o
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   initial begin
      assert (BYTE_W >= 2) else $fatal(1, "i2c_snoop_fsm: BYTE_W must be at least 2");
   end

   snoop_state_e      st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              dir_q;   // 1 = read
   logic              rep_q;   // a START seen since the last STOP
   logic [BYTE_W-1:0] addr_val;
   logic              item_done;

   generate
      if (RAW_ADDR) begin : g_addr_raw
         assign addr_val = sh_q;
      end else begin : g_addr_shift
         assign addr_val = {1'b0, sh_q[BYTE_W-1:1]};
      end
   endgenerate

   assign item_done = scl_rise_i && (cnt_q == LAST_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         cnt_q       <= '0;
         sh_q        <= '0;
         dir_q       <= 1'b0;
         rep_q       <= 1'b0;
         evt_valid_o <= 1'b0;
         evt_cmd_o   <= EV_START;
         evt_data_o  <= '0;
         evt_nack_o  <= 1'b0;
      end else begin
         evt_valid_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  evt_valid_o <= 1'b1;
                  evt_cmd_o   <= rep_q ? EV_RESTART : EV_START;
                  evt_data_o  <= '0;
                  evt_nack_o  <= 1'b0;
                  st_q        <= ST_ADDR;
                  cnt_q       <= '0;
                  sh_q        <= '0;
                  dir_q       <= 1'b0;
                  rep_q       <= 1'b1;
               end
            end
            ST_ADDR: begin
               // only clock edges matter while the address is arriving
               if (item_done) begin
                  evt_valid_o <= 1'b1;
                  evt_cmd_o   <= sh_q[0] ? EV_ADDR_RD : EV_ADDR_WR;
                  evt_data_o  <= addr_val;
                  evt_nack_o  <= sda_i;
                  dir_q       <= sh_q[0];
                  st_q        <= ST_DATA;
                  cnt_q       <= '0;
                  sh_q        <= '0;
               end else if (scl_rise_i) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            ST_DATA: begin
               if (item_done) begin
                  evt_valid_o <= 1'b1;
                  evt_cmd_o   <= dir_q ? EV_DATA_RD : EV_DATA_WR;
                  evt_data_o  <= sh_q;
                  evt_nack_o  <= sda_i;
                  cnt_q       <= '0;
                  sh_q        <= '0;
               end else if (scl_rise_i) begin
                  sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                  cnt_q <= cnt_q + CNT_W'(1);
               end else if (start_i) begin
                  evt_valid_o <= 1'b1;
                  evt_cmd_o   <= rep_q ? EV_RESTART : EV_START;
                  evt_data_o  <= '0;
                  evt_nack_o  <= 1'b0;
                  st_q        <= ST_ADDR;
                  cnt_q       <= '0;
                  sh_q        <= '0;
                  dir_q       <= 1'b0;
                  rep_q       <= 1'b1;
               end else if (stop_i) begin
                  evt_valid_o <= 1'b1;
                  evt_cmd_o   <= EV_STOP;
                  evt_data_o  <= '0;
                  evt_nack_o  <= 1'b0;
                  st_q        <= ST_IDLE;
                  cnt_q       <= '0;
                  sh_q        <= '0;
                  dir_q       <= 1'b0;
                  rep_q       <= 1'b0;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R10: an event always follows a condition seen by the edge stage
   p_evt_after_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_o |-> $past(scl_rise_i || start_i || stop_i));

   // R9: control events carry zero value and no NACK
   p_ctrl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid_o && (evt_cmd_o == EV_START || evt_cmd_o == EV_RESTART ||
                       evt_cmd_o == EV_STOP))
      |-> (evt_data_o == '0 && !evt_nack_o));

   // R3: a STOP event leaves the decoder idle
   p_stop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid_o && evt_cmd_o == EV_STOP) |-> (st_q == ST_IDLE));

   // R2: repeated START only comes out of the data phase
   p_restart_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid_o && evt_cmd_o == EV_RESTART) |-> ($past(st_q) == ST_DATA));

   // R6: direction is held through the data phase
   p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && !start_i && !stop_i) |=> $stable(dir_q));

   // R7: no event from the address phase without a clock edge
   p_addr_no_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ADDR && !scl_rise_i) |=> !evt_valid_o);

   // R4: bit counter never passes the acknowledge slot
   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_BIT);

endmodule

// File: rtl/i2c_snoop.sv
module i2c_snoop
   import i2c_snoop_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BYTE_W      = 8,
   parameter bit RAW_ADDR    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              evt_valid_o,
   output logic [2:0]        evt_cmd_o,
   output logic [BYTE_W-1:0] evt_data_o,
   output logic              evt_nack_o
);

   localparam int LINES = 2;

   logic [LINES-1:0] bus_s;
   logic             scl_rise;
   logic             start_c;
   logic             stop_c;
   evt_cmd_e         cmd_w;

   i2c_snoop_sync #(
      .STAGES  (SYNC_STAGES),
      .LINES   (LINES),
      .RST_VAL ({LINES{1'b1}})
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({scl_i, sda_i}),
      .q_o   (bus_s)
   );

   i2c_snoop_edge u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (bus_s[1]),
      .sda_i      (bus_s[0]),
      .scl_rise_o (scl_rise),
      .start_o    (start_c),
      .stop_o     (stop_c)
   );

   i2c_snoop_fsm #(
      .BYTE_W   (BYTE_W),
      .RAW_ADDR (RAW_ADDR)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise_i  (scl_rise),
      .start_i     (start_c),
      .stop_i      (stop_c),
      .sda_i       (bus_s[0]),
      .evt_valid_o (evt_valid_o),
      .evt_cmd_o   (cmd_w),
      .evt_data_o  (evt_data_o),
      .evt_nack_o  (evt_nack_o)
   );

   assign evt_cmd_o = cmd_w;

endmodule

// File: tb/sim_i2c_snoop.sv
module sim_i2c_snoop;

   localparam int HOLD = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       evt_valid;
   logic [2:0] evt_cmd;
   logic [7:0] evt_data;
   logic       evt_nack;

   int checks = 0;
   int errors = 0;
   int n_evt  = 0;
   bit done   = 1'b0;
   logic last_valid = 1'b0;

   logic [11:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   i2c_snoop u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda),
      .evt_valid_o (evt_valid),
      .evt_cmd_o   (evt_cmd),
      .evt_data_o  (evt_data),
      .evt_nack_o  (evt_nack)
   );

   task automatic hold_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic c, input logic d);
      scl = c;
      sda = d;
      hold_n(HOLD);
   endtask

   task automatic expect_evt(input logic [2:0] c, input logic [7:0] d,
                             input logic n, input string t);
      exp_q.push_back({c, d, n});
      tag_q.push_back(t);
   endtask

   task automatic bus_start();
      if (scl == 1'b0) begin
         drive(1'b0, 1'b1);
         drive(1'b1, 1'b1);
      end
      drive(1'b1, 1'b0);
   endtask

   task automatic bus_stop();
      drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
   endtask

   task automatic send_bit(input logic b);
      drive(1'b0, b);
      drive(1'b1, b);
      drive(1'b0, b);
   endtask

   // SCL rises in the same sample that SDA falls (R8)
   task automatic send_bit_race();
      drive(1'b0, 1'b1);
      drive(1'b1, 1'b0);
      drive(1'b0, 1'b0);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      send_bit(ack);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // monitor: compare each event with the scoreboard head
   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_valid) begin
            logic [11:0] got;
            logic [11:0] want;
            string       t;
            n_evt++;
            got = {evt_cmd, evt_data, evt_nack};
            checks++;
            if (last_valid) begin
               errors++;
               $display("FAIL R11 event strobe longer than one cycle: got 1 expected 0");
            end
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R10 unexpected event: got cmd=%0d data=%02h nack=%0b expected none",
                        evt_cmd, evt_data, evt_nack);
            end else begin
               want = exp_q.pop_front();
               t    = tag_q.pop_front();
               if (got !== want) begin
                  errors++;
                  $display("FAIL %s: got cmd=%0d data=%02h nack=%0b expected cmd=%0d data=%02h nack=%0b",
                           t, got[11:9], got[8:1], got[0], want[11:9], want[8:1], want[0]);
               end
            end
         end
         last_valid = evt_valid;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected run end");
         finish_run();
      end
   end

   initial begin
      hold_n(3);
      checks++;
      if (evt_valid !== 1'b0) begin
         errors++;
         $display("FAIL R10 strobe during reset: got %0b expected 0", evt_valid);
      end
      hold_n(2);
      rst_n = 1'b1;
      hold_n(30);
      checks++;
      if (n_evt != 0) begin
         errors++;
         $display("FAIL R10 events on idle bus: got %0d expected 0", n_evt);
      end

      // write transaction
      expect_evt(3'd0, 8'h00, 1'b0, "R1 R9");
      bus_start();
      drive(1'b1, 1'b1);   // R7: STOP-like change in address phase
      drive(1'b1, 1'b0);   // R7: START-like change in address phase
      expect_evt(3'd3, 8'h50, 1'b0, "R5 R7");
      send_byte(8'hA0, 1'b0);
      expect_evt(3'd5, 8'h3C, 1'b0, "R6 R4");
      send_byte(8'h3C, 1'b0);
      expect_evt(3'd5, 8'h81, 1'b0, "R6 R4");
      send_byte(8'h81, 1'b0);

      // repeated START and read transaction
      expect_evt(3'd1, 8'h00, 1'b0, "R2 R9");
      bus_start();
      expect_evt(3'd2, 8'h50, 1'b0, "R5");
      send_byte(8'hA1, 1'b0);
      expect_evt(3'd4, 8'hFE, 1'b0, "R6");
      send_byte(8'hFE, 1'b0);
      expect_evt(3'd4, 8'h80, 1'b1, "R8 R4");
      send_bit(1'b1);
      send_bit_race();
      for (int i = 0; i < 6; i++) send_bit(1'b0);
      send_bit(1'b1);
      expect_evt(3'd6, 8'h00, 1'b0, "R3 R9");
      bus_stop();

      // fresh START after STOP is not a repeat
      expect_evt(3'd0, 8'h00, 1'b0, "R2 R1");
      bus_start();
      expect_evt(3'd3, 8'h23, 1'b1, "R5 R4");
      send_byte(8'h46, 1'b1);
      expect_evt(3'd6, 8'h00, 1'b0, "R3");
      bus_stop();

      hold_n(20);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R11 missing events: got %0d left expected 0", exp_q.size());
      end
      checks++;
      if (n_evt != 12) begin
         errors++;
         $display("FAIL R11 event count: got %0d expected 12", n_evt);
      end
      done = 1'b1;
      finish_run();
   end

endmodule